// File: doc/BRIEF.md
# Phase-Compensated Frequency Retune Sequencer

This block turns one retune command into a timed series of register writes on a narrow synthesiser control bus. A command carries a channel number, a tuning word, a phase word, an amplitude, a phase mode, an optional reference time and the timestamp at which the final update strobe must appear. The sequencer schedules its writes backwards from that timestamp, one write every five clock cycles, so that the strobe lands in the cycle whose time value equals the requested timestamp.

Before the phase register is written, the block works out the phase correction in 64-bit arithmetic. It takes the time gap between the reference time and a fixed strobe estimate, multiplies it by the number of synthesiser clocks per time unit and by the tuning word, and keeps bits 31:16 of the product. In continuous mode it instead adds a stored compensation word, which every ordinary retune leaves equal to the phase word it wrote. A second command form sends a 63-bit tuning word in four pieces for extended frequency resolution. A command whose timestamp leaves no room for its writes, or one that arrives while a series is still in progress, raises a one-cycle error and is dropped.

The block takes its time value from the chip's timebase. That value must advance by exactly one on every clock.

Top module: `dds_retune_seq`

## Requirements
- R1: After reset, wr_valid, busy and cmd_err are low and the stored compensation word is zero. A first continuous-mode command therefore writes its phase word unchanged.
- R2: A normal command (cmd_ext=0) with timestamp T writes addresses 0x81, 0x2D (tuning bits 15:0), 0x2F (tuning bits 31:16), 0x01, 0x31, 0x33 ({4'b0, amplitude}) and then the strobe 0x80 with data 0. The writes are one cycle each and five cycles apart, and the strobe falls in the cycle where now_time equals T.
- R3: An extended command (cmd_ext=1) writes 0x81, then 0x07 with 0x0089, 0x19 with word bits 15:0, 0x1B with {0, bits 30:16}, 0x11 with bits 46:31, 0x13 with bits 62:47, 0x33 with the amplitude, and then the strobe 0x80. The writes are five cycles apart and the strobe falls at T. Extended commands leave the compensation word unchanged.
- R4: Phase mode 0 (continuous) writes 0x0108 to address 0x01. Modes 1, 2 and 3 write 0x2108, which sets accumulator clearing on update.
- R5: In modes 1 and 3 the phase written is pow − ((ref − (T − 5)) × CLK_PER_TICK × tuning[31:0])[31:16], computed modulo 2^64. When cmd_ref_valid is low, ref equals T.
- R6: In mode 2 the phase written is the R5 value plus (ref × CLK_PER_TICK × tuning[31:0])[31:16].
- R7: In mode 0 the phase written is pow plus the stored compensation word. After every normal command, the compensation word becomes the phase word that command wrote.
- R8: A command with T − now_time below 32 (normal) or 37 (extended) produces no writes and leaves busy low. cmd_err is high for the one cycle after the command. A command exactly at the limit is carried out.
- R9: A command that arrives while busy is high raises cmd_err in the next cycle and is dropped. The series in progress goes on unchanged.
- R10: busy is high from the cycle after a command is accepted through the cycle before its strobe, and low in the strobe cycle, so a new command is accepted in that cycle. wr_addr and wr_data are zero whenever wr_valid is low.
- R11: The first write of every series goes to 0x81 with data 1 << (cmd_chan + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_time | input | 64 | Timebase value, one step per clock |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ext | input | 1 | Extended-resolution command |
| cmd_chan | input | 3 | Channel to select |
| cmd_ftw | input | 63 | Tuning word (bits 31:0 for normal commands) |
| cmd_pow | input | 16 | Phase word |
| cmd_asf | input | 12 | Amplitude |
| cmd_mode | input | 2 | Phase mode: 0 continuous, 1 absolute, 2 tracking, 3 absolute |
| cmd_ref_valid | input | 1 | Reference time supplied |
| cmd_ref_time | input | 64 | Reference time |
| cmd_time | input | 64 | Requested strobe timestamp |
| busy | output | 1 | Series in progress |
| cmd_err | output | 1 | Previous-cycle command was dropped |
| wr_valid | output | 1 | Bus write this cycle |
| wr_addr | output | 8 | Bus write address |
| wr_data | output | 16 | Bus write data |

## Verification
Two functions can fall in the same cycle. The strobe of one series can coincide with the acceptance of the next command, and the last writes of a series can coincide with a command that is refused. The bench drives a new command in exactly the cycle where now_time equals the previous timestamp. It also drives commands a few cycles into a running series, and a pseudo-random stream with random gaps that hits both cases again. A behavioural model keeps a queue of timed writes, the busy window and the expected error pulse, and compares them on every cycle. It therefore judges both that the strobe is not disturbed and that the new series starts on its own schedule, or that the refused command leaves no trace.

// File: rtl/dds_retune_pkg.sv
// Package: shared constants and types for the frequency retune sequencer.
// Assumes: a write occupies one bus cycle and writes are WR_GAP cycles apart.
package dds_retune_pkg;

    localparam int WR_GAP = 5;
    localparam int SLOT_W = 3;

    localparam int SET_LAST   = 6;
    localparam int EXT_LAST   = 7;
    localparam int CFG_SLOT   = 3;
    localparam int PHASE_SLOT = 4;

    localparam logic [7:0] ADR_SELECT    = 8'h81;
    localparam logic [7:0] ADR_STROBE    = 8'h80;
    localparam logic [7:0] ADR_FREQ_LO   = 8'h2D;
    localparam logic [7:0] ADR_FREQ_HI   = 8'h2F;
    localparam logic [7:0] ADR_MODE_CFG  = 8'h01;
    localparam logic [7:0] ADR_PHASE     = 8'h31;
    localparam logic [7:0] ADR_AMP       = 8'h33;
    localparam logic [7:0] ADR_CTRL2_HI  = 8'h07;
    localparam logic [7:0] ADR_XWORD_LO  = 8'h19;
    localparam logic [7:0] ADR_XWORD_MID = 8'h1B;
    localparam logic [7:0] ADR_XFRAC_LO  = 8'h11;
    localparam logic [7:0] ADR_XFRAC_HI  = 8'h13;

    localparam logic [15:0] CFG_KEEP_ACC  = 16'h0108;
    localparam logic [15:0] CFG_CLEAR_ACC = 16'h2108;
    localparam logic [15:0] CTRL2_EXTRES  = 16'h0089;

    typedef enum logic [1:0] {
        PM_CONT   = 2'd0,
        PM_ABS    = 2'd1,
        PM_TRACK  = 2'd2,
        PM_ABS_B  = 2'd3
    } phase_mode_e;

    typedef struct packed {
        logic        ext;
        phase_mode_e mode;
        logic [62:0] freq;
        logic [15:0] phase;
        logic [11:0] amp;
    } retune_cmd_t;

endpackage

// File: rtl/dds_phase_calc.sv
// Module: phase correction arithmetic.
// Computes the phase word to write from the latched command, the resolved
// reference time and the stored compensation word. Purely combinational.
// Assumes: TIME_W >= 32; only bits 31:16 of each product reach the output.
module dds_phase_calc
    import dds_retune_pkg::*;
#(
    parameter int TIME_W       = 64,
    parameter int CLK_PER_TICK = 4
) (
    input  phase_mode_e        mode,
    input  logic [31:0]        freq,
    input  logic [15:0]        phase_in,
    input  logic [TIME_W-1:0]  ref_time,
    input  logic [TIME_W-1:0]  tgt_time,
    input  logic [15:0]        comp,
    output logic [15:0]        phase_out
);
    // Distance from the strobe timestamp back to the strobe estimate used in
    // the correction: config write time plus two write slots.
    localparam int STROBE_BACK = (SET_LAST - CFG_SLOT - 2) * WR_GAP;

    logic [TIME_W-1:0] strobe_est;
    logic [TIME_W-1:0] gap_prod;
    logic [TIME_W-1:0] abs_prod;
    logic [15:0]       gap_corr;
    logic [15:0]       abs_corr;

    assign strobe_est = tgt_time - TIME_W'(STROBE_BACK);
    assign gap_prod   = (ref_time - strobe_est) * TIME_W'(CLK_PER_TICK) * TIME_W'(freq);
    assign abs_prod   = ref_time * TIME_W'(CLK_PER_TICK) * TIME_W'(freq);
    assign gap_corr   = 16'(gap_prod >> 16);
    assign abs_corr   = 16'(abs_prod >> 16);

    // Select the phase formula by mode.
    always_comb begin
        unique case (mode)
            PM_CONT:  phase_out = phase_in + comp;
            PM_TRACK: phase_out = phase_in - gap_corr + abs_corr;
            default:  phase_out = phase_in - gap_corr;
        endcase
    end

endmodule

// File: rtl/dds_slot_table.sv
// Module: write slot decoder.
// Maps a slot index of the running series to a bus address and data word,
// for both the normal and the extended-resolution series.
// Assumes: 2**CHAN_W + 1 < 16 so the select bit fits the data word.
module dds_slot_table
    import dds_retune_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  retune_cmd_t        cmd,
    input  logic [CHAN_W-1:0]  chan,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [15:0]        phase_word,
    output logic [7:0]         addr,
    output logic [15:0]        data
);
    logic [15:0] sel_word;
    logic [15:0] cfg_word;
    logic [15:0] amp_word;

    assign sel_word = 16'd2 << chan;
    assign cfg_word = (cmd.mode == PM_CONT) ? CFG_KEEP_ACC : CFG_CLEAR_ACC;
    assign amp_word = {4'd0, cmd.amp};

    // Decode one slot of the selected series.
    always_comb begin
        addr = ADR_STROBE;
        data = 16'd0;
        if (cmd.ext) begin
            unique case (slot)
                3'd0: begin addr = ADR_SELECT;    data = sel_word;               end
                3'd1: begin addr = ADR_CTRL2_HI;  data = CTRL2_EXTRES;           end
                3'd2: begin addr = ADR_XWORD_LO;  data = cmd.freq[15:0];         end
                3'd3: begin addr = ADR_XWORD_MID; data = {1'b0, cmd.freq[30:16]}; end
                3'd4: begin addr = ADR_XFRAC_LO;  data = cmd.freq[46:31];        end
                3'd5: begin addr = ADR_XFRAC_HI;  data = cmd.freq[62:47];        end
                3'd6: begin addr = ADR_AMP;       data = amp_word;               end
                default: begin addr = ADR_STROBE; data = 16'd0;                  end
            endcase
        end else begin
            unique case (slot)
                3'd0: begin addr = ADR_SELECT;   data = sel_word;            end
                3'd1: begin addr = ADR_FREQ_LO;  data = cmd.freq[15:0];      end
                3'd2: begin addr = ADR_FREQ_HI;  data = cmd.freq[31:16];     end
                3'd3: begin addr = ADR_MODE_CFG; data = cfg_word;            end
                3'd4: begin addr = ADR_PHASE;    data = phase_word;          end
                3'd5: begin addr = ADR_AMP;      data = amp_word;            end
                default: begin addr = ADR_STROBE; data = 16'd0;              end
            endcase
        end
    end

endmodule

// File: rtl/dds_write_timer.sv
// Module: write scheduler.
// Accepts or refuses a request against the timebase. It waits until the
// first write time, then issues one slot every WR_GAP cycles up to the last.
// Assumes: now_time advances by exactly one per clock.
module dds_write_timer
    import dds_retune_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  now_time,
    input  logic               req,
    input  logic [SLOT_W-1:0]  req_last,
    input  logic [TIME_W-1:0]  req_time,
    output logic               take,
    output logic               refuse,
    output logic               busy,
    output logic               fire,
    output logic [SLOT_W-1:0]  slot
);
    localparam int GAP_W = $clog2(WR_GAP);
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(WR_GAP - 1);

    typedef enum logic [1:0] {TM_IDLE, TM_WAIT, TM_ISSUE} tm_state_e;

    tm_state_e          state_q;
    logic [TIME_W-1:0]  start_m1_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [SLOT_W-1:0]  last_q;
    logic [GAP_W-1:0]   gap_q;

    logic [TIME_W-1:0]  lead;
    logic [TIME_W-1:0]  slack;
    logic               too_close;

    // Lead time and slack check for an incoming request.
    assign lead      = TIME_W'(req_last) * TIME_W'(WR_GAP);
    assign slack     = req_time - now_time;
    assign too_close = $signed(slack) < $signed(lead + TIME_W'(2));

    assign busy   = (state_q != TM_IDLE);
    assign take   = req && !busy && !too_close;
    assign refuse = req && (busy || too_close);
    assign fire   = ((state_q == TM_WAIT) && (now_time == start_m1_q)) ||
                    ((state_q == TM_ISSUE) && (gap_q == '0));
    assign slot   = slot_q;

    // Sequence state: idle, waiting for the first slot, issuing slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TM_IDLE;
            start_m1_q <= '0;
            slot_q     <= '0;
            last_q     <= '0;
            gap_q      <= '0;
        end else begin
            unique case (state_q)
                TM_IDLE: begin
                    if (take) begin
                        start_m1_q <= req_time - lead - TIME_W'(1);
                        last_q     <= req_last;
                        slot_q     <= '0;
                        state_q    <= TM_WAIT;
                    end
                end
                TM_WAIT: begin
                    if (fire) begin
                        slot_q  <= SLOT_W'(1);
                        gap_q   <= GAP_RELOAD;
                        state_q <= TM_ISSUE;
                    end
                end
                TM_ISSUE: begin
                    if (gap_q == '0) begin
                        if (slot_q == last_q) begin
                            state_q <= TM_IDLE;
                        end else begin
                            slot_q <= slot_q + SLOT_W'(1);
                            gap_q  <= GAP_RELOAD;
                        end
                    end else begin
                        gap_q <= gap_q - GAP_W'(1);
                    end
                end
                default: state_q <= TM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dds_retune_seq.sv
// Module: phase-compensated frequency retune sequencer (top).
// Latches one command, schedules its register writes so the strobe lands at
// the requested timestamp, computes the phase word and keeps the
// continuous-mode compensation word between commands.
// Assumes: now_time advances by one per clock; commands are not queued.
module dds_retune_seq
    import dds_retune_pkg::*;
#(
    parameter int TIME_W       = 64,
    parameter int CHAN_W       = 3,
    parameter int CLK_PER_TICK = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  now_time,
    input  logic               cmd_valid,
    input  logic               cmd_ext,
    input  logic [CHAN_W-1:0]  cmd_chan,
    input  logic [62:0]        cmd_ftw,
    input  logic [15:0]        cmd_pow,
    input  logic [11:0]        cmd_asf,
    input  logic [1:0]         cmd_mode,
    input  logic               cmd_ref_valid,
    input  logic [TIME_W-1:0]  cmd_ref_time,
    input  logic [TIME_W-1:0]  cmd_time,
    output logic               busy,
    output logic               cmd_err,
    output logic               wr_valid,
    output logic [7:0]         wr_addr,
    output logic [15:0]        wr_data
);
    retune_cmd_t        cmd_q;
    logic [CHAN_W-1:0]  chan_q;
    logic [TIME_W-1:0]  ref_q;
    logic [TIME_W-1:0]  tgt_q;
    logic [15:0]        comp_q;

    logic               take;
    logic               refuse;
    logic               fire;
    logic [SLOT_W-1:0]  slot;
    logic [SLOT_W-1:0]  req_last;
    logic [15:0]        phase_word;
    logic [7:0]         slot_addr;
    logic [15:0]        slot_data;

    logic               err_q;
    logic               wr_valid_q;
    logic [7:0]         wr_addr_q;
    logic [15:0]        wr_data_q;

    assign req_last = cmd_ext ? SLOT_W'(EXT_LAST) : SLOT_W'(SET_LAST);

    dds_write_timer #(
        .TIME_W   (TIME_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .now_time (now_time),
        .req      (cmd_valid),
        .req_last (req_last),
        .req_time (cmd_time),
        .take     (take),
        .refuse   (refuse),
        .busy     (busy),
        .fire     (fire),
        .slot     (slot)
    );

    dds_phase_calc #(
        .TIME_W       (TIME_W),
        .CLK_PER_TICK (CLK_PER_TICK)
    ) calc_i (
        .mode      (cmd_q.mode),
        .freq      (cmd_q.freq[31:0]),
        .phase_in  (cmd_q.phase),
        .ref_time  (ref_q),
        .tgt_time  (tgt_q),
        .comp      (comp_q),
        .phase_out (phase_word)
    );

    dds_slot_table #(
        .CHAN_W (CHAN_W)
    ) table_i (
        .cmd        (cmd_q),
        .chan       (chan_q),
        .slot       (slot),
        .phase_word (phase_word),
        .addr       (slot_addr),
        .data       (slot_data)
    );

    // Latch the accepted command and resolve a missing reference time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            chan_q <= '0;
            ref_q  <= '0;
            tgt_q  <= '0;
        end else if (take) begin
            cmd_q.ext   <= cmd_ext;
            cmd_q.mode  <= phase_mode_e'(cmd_mode);
            cmd_q.freq  <= cmd_ftw;
            cmd_q.phase <= cmd_pow;
            cmd_q.amp   <= cmd_asf;
            chan_q      <= cmd_chan;
            ref_q       <= cmd_ref_valid ? cmd_ref_time : cmd_time;
            tgt_q       <= cmd_time;
        end
    end

    // Carry the written phase word forward as the compensation word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q <= '0;
        end else if (fire && !cmd_q.ext && (slot == SLOT_W'(PHASE_SLOT))) begin
            comp_q <= phase_word;
        end
    end

    // Register the bus write; address and data return to zero between writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else if (fire) begin
            wr_valid_q <= 1'b1;
            wr_addr_q  <= slot_addr;
            wr_data_q  <= slot_data;
        end else begin
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end
    end

    // One-cycle error pulse for a dropped command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= refuse;
        end
    end

    assign cmd_err  = err_q;
    assign wr_valid = wr_valid_q;
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;

endmodule

// File: rtl/dds_retune_chk.sv
// Module: property checker for the retune sequencer, bound to the top.
// Assumes: connected to the top's ports plus the latched target time and
// the compensation word.
module dds_retune_chk
    import dds_retune_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TIME_W-1:0]  now_time,
    input logic               cmd_valid,
    input logic               busy,
    input logic               cmd_err,
    input logic               wr_valid,
    input logic [7:0]         wr_addr,
    input logic [15:0]        wr_data,
    input logic [TIME_W-1:0]  tgt_q,
    input logic [15:0]        comp_q
);
    logic       seq_open;
    logic [7:0] since_wr;

    // Track the distance from the last write within an open series.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_open <= 1'b0;
            since_wr <= '0;
        end else if (wr_valid) begin
            seq_open <= (wr_addr != ADR_STROBE);
            since_wr <= '0;
        end else if (since_wr != 8'hFF) begin
            since_wr <= since_wr + 8'd1;
        end
    end

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (wr_addr == 8'd0 && wr_data == 16'd0)); // R10
    AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && seq_open) |-> (since_wr == 8'(WR_GAP - 1))); // R2
    AST_STROBE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADR_STROBE) |-> (now_time == tgt_q && !busy)); // R2
    AST_SELECT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADR_SELECT) |-> ($countones(wr_data) == 1)); // R11
    AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid)); // R8
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_err); // R9
    AST_COMP_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(comp_q) |-> (wr_valid && wr_addr == ADR_PHASE)); // R7

endmodule

bind dds_retune_seq dds_retune_chk #(
    .TIME_W (TIME_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .now_time  (now_time),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .cmd_err   (cmd_err),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tgt_q     (tgt_q),
    .comp_q    (comp_q)
);

// File: tb/dds_retune_seq_tb_top.sv
`timescale 1ns/1ps
module dds_retune_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_t = 64'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ext = 1'b0;
    logic [2:0]  cmd_chan = '0;
    logic [62:0] cmd_ftw = '0;
    logic [15:0] cmd_pow = '0;
    logic [11:0] cmd_asf = '0;
    logic [1:0]  cmd_mode = '0;
    logic        cmd_ref_valid = 1'b0;
    logic [63:0] cmd_ref_time = '0;
    logic [63:0] cmd_time = '0;
    logic        busy;
    logic        cmd_err;
    logic        wr_valid;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dds_retune_seq dut_i (
        .clk(clk), .rst_n(rst_n), .now_time(now_t),
        .cmd_valid(cmd_valid), .cmd_ext(cmd_ext), .cmd_chan(cmd_chan),
        .cmd_ftw(cmd_ftw), .cmd_pow(cmd_pow), .cmd_asf(cmd_asf),
        .cmd_mode(cmd_mode), .cmd_ref_valid(cmd_ref_valid),
        .cmd_ref_time(cmd_ref_time), .cmd_time(cmd_time),
        .busy(busy), .cmd_err(cmd_err),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Timebase: one step per clock.
    always @(posedge clk) now_t <= now_t + 64'd1;

    // ---------------- reference model ----------------
    typedef struct {
        logic [63:0] t;
        logic [7:0]  addr;
        logic [15:0] data;
        string       tag;
    } wr_t;

    wr_t         expq[$];
    logic [63:0] acc_n = 64'd0;
    logic [63:0] end_t = 64'd0;
    logic [15:0] comp_m = 16'd0;
    logic        err_exp = 1'b0;
    string       err_tag = "R8";
    bit          first_set = 1'b1;

    task automatic push_wr(input logic [63:0] t, input logic [7:0] a,
                           input logic [15:0] d, input string tag);
        wr_t e;
        e.t = t; e.addr = a; e.data = d; e.tag = tag;
        expq.push_back(e);
    endtask

    always @(posedge clk) begin
        logic [63:0] n, tt, s, rf, p1, p2, lead;
        logic [15:0] ph;
        string ptag;
        n = now_t;
        if (!rst_n) begin
            expq.delete();
            acc_n = 0; end_t = 0; comp_m = 0; err_exp = 0; first_set = 1;
        end else begin
            err_exp = 0;
            if (cmd_valid) begin
                tt = cmd_time;
                lead = cmd_ext ? 64'd35 : 64'd30;
                if (n > acc_n && n < end_t) begin
                    err_exp = 1; err_tag = "R9";
                end else if ($signed(tt - n) < $signed(lead + 64'd2)) begin
                    err_exp = 1; err_tag = "R8";
                end else begin
                    acc_n = n; end_t = tt; s = tt - lead;
                    push_wr(s, 8'h81, 16'd2 << cmd_chan, "R11");
                    if (cmd_ext) begin
                        push_wr(s + 5,  8'h07, 16'h0089, "R3");
                        push_wr(s + 10, 8'h19, cmd_ftw[15:0], "R3");
                        push_wr(s + 15, 8'h1B, {1'b0, cmd_ftw[30:16]}, "R3");
                        push_wr(s + 20, 8'h11, cmd_ftw[46:31], "R3");
                        push_wr(s + 25, 8'h13, cmd_ftw[62:47], "R3");
                        push_wr(s + 30, 8'h33, {4'd0, cmd_asf}, "R3");
                        push_wr(s + 35, 8'h80, 16'd0, "R3");
                    end else begin
                        rf = cmd_ref_valid ? cmd_ref_time : tt;
                        if (cmd_mode == 2'd0) begin
                            ph = cmd_pow + comp_m;
                            ptag = first_set ? "R1" : "R7";
                        end else begin
                            p1 = (rf - (tt - 64'd5)) * 64'd4 * {32'd0, cmd_ftw[31:0]};
                            ph = cmd_pow - p1[31:16];
                            ptag = "R5";
                            if (cmd_mode == 2'd2) begin
                                p2 = rf * 64'd4 * {32'd0, cmd_ftw[31:0]};
                                ph = ph + p2[31:16];
                                ptag = "R6";
                            end
                        end
                        comp_m = ph;
                        first_set = 0;
                        push_wr(s + 5,  8'h2D, cmd_ftw[15:0], "R2");
                        push_wr(s + 10, 8'h2F, cmd_ftw[31:16], "R2");
                        push_wr(s + 15, 8'h01, (cmd_mode == 2'd0) ? 16'h0108 : 16'h2108, "R4");
                        push_wr(s + 20, 8'h31, ph, ptag);
                        push_wr(s + 25, 8'h33, {4'd0, cmd_asf}, "R2");
                        push_wr(s + 30, 8'h80, 16'd0, "R2");
                    end
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h at t=%0d", tag, what, act, exp, now_t);
        end
    endtask

    always @(negedge clk) begin
        bit busy_exp;
        if (!rst_n) begin
            chk(!wr_valid && !busy && !cmd_err, "R1", "reset outputs",
                {61'd0, wr_valid, busy, cmd_err}, 64'd0);
        end else begin
            while (expq.size() > 0 && expq[0].t < now_t) begin
                chk(1'b0, expq[0].tag, "missed write", 64'd0, {48'd0, expq[0].addr, 8'd0});
                void'(expq.pop_front());
            end
            if (expq.size() > 0 && expq[0].t == now_t) begin
                chk(wr_valid && wr_addr == expq[0].addr && wr_data == expq[0].data,
                    expq[0].tag, "write",
                    {39'd0, wr_valid, wr_addr, wr_data},
                    {39'd0, 1'b1, expq[0].addr, expq[0].data});
                void'(expq.pop_front());
            end else begin
                chk(!wr_valid && wr_addr == 0 && wr_data == 0, "R10", "idle bus",
                    {39'd0, wr_valid, wr_addr, wr_data}, 64'd0);
            end
            busy_exp = (now_t > acc_n) && (now_t < end_t);
            chk(busy == busy_exp, "R10", "busy", {63'd0, busy}, {63'd0, busy_exp});
            chk(cmd_err == err_exp, err_tag, "cmd_err", {63'd0, cmd_err}, {63'd0, err_exp});
        end
    end

    // ---------------- stimulus ----------------
    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic send(input bit ext, input logic [2:0] ch, input logic [62:0] ftw,
                        input logic [15:0] pw, input logic [11:0] amp, input logic [1:0] md,
                        input bit rv, input logic [63:0] rt, input int dt);
        cmd_valid = 1; cmd_ext = ext; cmd_chan = ch; cmd_ftw = ftw;
        cmd_pow = pw; cmd_asf = amp; cmd_mode = md; cmd_ref_valid = rv;
        cmd_ref_time = rt; cmd_time = now_t + 64'(dt);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        while (now_t <= end_t + 64'd1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        logic [63:0] ta;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 / R7: first continuous command writes its phase unchanged.
        send(0, 3'd2, 63'h1234_5678, 16'h1111, 12'hABC, 2'd0, 0, 0, 40); wait_idle();
        // R3: extended series.
        send(1, 3'd5, 63'h7ABC_DEF0_1234_5678, 16'h0, 12'h7FF, 2'd1, 0, 0, 50); wait_idle();
        // R5: absolute with a supplied reference.
        send(0, 3'd0, 63'h0F0F_1234, 16'h4000, 12'h123, 2'd1, 1, 64'h1000, 60); wait_idle();
        // R6: tracking with default reference.
        send(0, 3'd7, 63'h8765_4321, 16'h0101, 12'hFFF, 2'd2, 0, 0, 45); wait_idle();
        // R4 / R5: mode 3 behaves as absolute.
        send(0, 3'd1, 63'h0000_FFFF, 16'h7777, 12'h001, 2'd3, 1, 64'hFFFF_FFFF_0000_0010, 33); wait_idle();
        // R7: continuous after a non-zero compensation word.
        send(0, 3'd3, 63'h1111_2222, 16'h0202, 12'h555, 2'd0, 0, 0, 40); wait_idle();
        // R8: too close, then exactly at the limit.
        send(0, 3'd4, 63'h5, 16'h1, 12'h2, 2'd0, 0, 0, 31);
        send(0, 3'd4, 63'h5, 16'h1, 12'h2, 2'd0, 0, 0, 32); wait_idle();
        send(1, 3'd6, 63'h1, 16'h1, 12'h3, 2'd0, 0, 0, 36);
        send(1, 3'd6, 63'h1, 16'h1, 12'h3, 2'd0, 0, 0, 37); wait_idle();
        // R9: command while busy is dropped.
        send(0, 3'd2, 63'hABCD, 16'h9, 12'h9, 2'd2, 0, 0, 50);
        repeat (3) @(negedge clk);
        send(0, 3'd3, 63'hDCBA, 16'h8, 12'h8, 2'd1, 0, 0, 80); wait_idle();
        // R10: new command in the strobe cycle of the previous one.
        ta = now_t + 64'd40;
        send(0, 3'd1, 63'h3333, 16'h3, 12'h3, 2'd0, 0, 0, 40);
        while (now_t != ta) @(negedge clk);
        send(1, 3'd2, 63'h4444_5555_6666, 16'h4, 12'h4, 2'd0, 0, 0, 45); wait_idle();
        // Mixed pseudo-random stream with random gaps.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b, c;
            a = rnd(); b = rnd(); c = rnd();
            send(a[0], a[3:1], {b[30:0], c}, a[31:16], b[11:0], a[5:4], a[6],
                 {c, b}, 32 + int'(a[12:8]) % 40);
            repeat (int'(c[5:0])) @(negedge clk);
        end
        wait_idle();
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog act=running exp=finished");
        finish_run();
    end

endmodule